// File: doc/BRIEF.md
# Split Approximate Adder

This block is a combinational adder that trades accuracy in the low half of its operands for a shorter carry path. The operands are split at the middle bit. The upper half is added exactly, with its carry-in tied to zero. The lower half produces no carry. Each of its bits is the exclusive-or of the two operand bits until the scan, going from the top of the lower half downward, meets a position where both operand bits are one. That position and every position below it are then driven to one. This keeps the error distance small while no carry chain runs across the lower half.

The block suits datapaths that tolerate small numeric error, such as image or audio filters. In those datapaths the shorter critical path, or the lower switching activity, matters more than an exact least-significant half. The result is one bit wider than the operands so that the carry out of the exact half is kept.

Top module: `split_approx_adder`

## Requirements
- R1: Result bits WIDTH down to L, where L = floor(WIDTH/2), equal the exact sum of operand bits WIDTH-1..L of both inputs with a carry-in of zero. Result bit WIDTH is the carry out of that addition.
- R2: When no lower position (bits L-1..0) has both operand bits set, result bits L-1..0 equal the bitwise exclusive-or of the operands' lower bits.
- R3: When k is the highest lower position with both operand bits set, result bits k..0 are all one.
- R4: Result bits L-1..k+1, the lower positions above that highest both-set position k, equal the exclusive-or of the operand bits at the same positions.
- R5: No carry leaves the lower half. With the upper operand bits held fixed, any change to the lower operand bits leaves result bits WIDTH..L unchanged.
- R6: The result never exceeds the exact sum. It equals the exact sum exactly when no lower position has both operand bits set.
- R7: WIDTH is a parameter with a default of 16. The lower half is floor(WIDTH/2) bits wide, and the upper half takes the remaining bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sum_o | output | WIDTH+1 | Approximate sum; the top bit is the carry out of the exact half |

## Verification
On every evaluation, the assertions check four things:
- The upper field of the result matches an exact addition of the upper halves.
- The result never exceeds the true sum, and it equals the true sum exactly when the lower halves share no set bit.
- The lower field is a plain exclusive-or when the lower halves share no set bit.
- Every bit at or below a shared set bit reads one.

The bench scenarios show three behaviours that a per-evaluation check cannot show:
- Sweeping only the lower bits under a fixed upper half leaves the upper field unchanged.
- Bits above the highest shared position keep their exclusive-or value.
- The design matches a reference model across a whole 6-bit configuration.

The bench also reports error rate and mean error distance against exact addition.

// File: rtl/split_approx_adder.sv
module split_approx_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH:0]   sum_o
);
  localparam int LO = WIDTH / 2;
  localparam int HI = WIDTH - LO;

  logic [HI:0]   hi_sum;
  logic [LO-1:0] both;
  logic [LO-1:0] lock;
  logic [LO-1:0] lo_sum;

  assign hi_sum = {1'b0, a_i[WIDTH-1:LO]} + {1'b0, b_i[WIDTH-1:LO]};
  assign both   = a_i[LO-1:0] & b_i[LO-1:0];

  for (genvar i = 0; i < LO; i++) begin : g_low
    if (i == LO - 1) begin : g_top
      assign lock[i] = both[i];
    end else begin : g_rest
      assign lock[i] = both[i] | lock[i+1];
    end
    assign lo_sum[i] = lock[i] | (a_i[i] ^ b_i[i]);
  end

  assign sum_o = {hi_sum, lo_sum};
endmodule

// File: rtl/split_approx_adder_chk.sv
module split_approx_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH:0]   sum_o
);
  localparam int LO = WIDTH / 2;
  localparam int HI = WIDTH - LO;

  logic [WIDTH:0] exact;
  logic [HI:0]    upper;
  logic [LO-1:0]  shared;

  assign exact  = {1'b0, a_i} + {1'b0, b_i};
  assign upper  = {1'b0, a_i[WIDTH-1:LO]} + {1'b0, b_i[WIDTH-1:LO]};
  assign shared = a_i[LO-1:0] & b_i[LO-1:0];

  always_comb begin
    AST_UPPER_EXACT: assert (sum_o[WIDTH:LO] == upper); // R1
    AST_NO_EXCESS: assert (sum_o <= exact); // R6
    AST_EXACT_IFF_DISJOINT: assert ((sum_o == exact) == (shared == '0)); // R6
    AST_DISJOINT_XOR: assert (shared != '0 || sum_o[LO-1:0] == (a_i[LO-1:0] ^ b_i[LO-1:0])); // R2
    for (int i = 0; i < LO; i++) begin
      for (int j = 0; j <= i; j++) begin
        AST_FILL_BELOW: assert (!shared[i] || sum_o[j]); // R3
      end
    end
  end
endmodule

bind split_approx_adder split_approx_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i), .b_i(b_i), .sum_o(sum_o)
);

// File: tb/test_split_approx_adder.sv
`timescale 1ns/1ps
module test_split_approx_adder;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [15:0] a16 = '0, b16 = '0;
  logic [16:0] s16;
  logic [5:0]  a6 = '0, b6 = '0;
  logic [6:0]  s6;

  split_approx_adder #(.WIDTH(16)) i_split_approx_adder (.a_i(a16), .b_i(b16), .sum_o(s16));
  split_approx_adder #(.WIDTH(6))  i_split_approx_adder_w6 (.a_i(a6), .b_i(b6), .sum_o(s6));

  function automatic longint model(longint a, longint b, int w);
    int lo = w / 2;
    longint r = 0;
    bit sat = 0;
    longint hi = (a >> lo) + (b >> lo);
    for (int i = lo - 1; i >= 0; i--) begin
      bit ab = bit'((a >> i) & 1);
      bit bb = bit'((b >> i) & 1);
      if (ab && bb) sat = 1;
      if (sat || (ab ^ bb)) r = r | (longint'(1) << i);
    end
    return (hi << lo) | r;
  endfunction

  task automatic chk(input longint act, input longint exp, input string tag);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive16(input logic [15:0] a, input logic [15:0] b);
    @(posedge clk);
    a16 = a; b16 = b;
    @(negedge clk);
  endtask

  task automatic drive6(input logic [5:0] a, input logic [5:0] b);
    @(posedge clk);
    a6 = a; b6 = b;
    @(negedge clk);
  endtask

  initial begin
    longint ex, ap, errsum;
    int nwrong;
    logic [7:0] up0;

    drive16(16'h0000, 16'h0000);
    chk(s16, 17'h00000, "R1 zero operands");

    drive16(16'h8000, 16'h8000);
    chk(s16, 17'h10000, "R1 carry out of upper half");
    drive16(16'h00F0, 16'h000F);
    chk(s16, 17'h000FF, "R2 disjoint lower bits");
    drive16(16'h0080, 16'h0080);
    chk(s16, 17'h000FF, "R3 shared top lower bit");
    drive16(16'hFFFF, 16'h0001);
    chk(s16, 17'h0FFFF, "R5 no carry out of lower half");
    drive16(16'h00A4, 16'h0034);
    chk(s16, 17'h000BF, "R4 xor above shared bit 5");
    drive16(16'h1234, 16'h4321);
    chk(s16, 17'h0553F, "R4 upper sum with shared bit 5");

    for (int n = 0; n < 64; n++) begin
      drive16({8'h7F, 8'($urandom)}, {8'h01, 8'($urandom)});
      chk(s16[16:8], 9'h080, "R5 upper field fixed");
    end

    nwrong = 0; errsum = 0;
    for (int n = 0; n < 2000; n++) begin
      drive16(16'($urandom), 16'($urandom));
      ex = longint'(a16) + longint'(b16);
      ap = longint'(s16);
      chk(ap, model(a16, b16, 16), "R3 R4 random width 16");
      chk(longint'(ap <= ex), 1, "R6 no excess");
      chk(longint'(ap == ex), longint'((a16[7:0] & b16[7:0]) == 8'h00), "R6 exact iff disjoint");
      if (ap != ex) nwrong++;
      errsum += ex - ap;
    end
    $display("width 16 random: error rate %0d/2000, mean error distance %0.3f",
             nwrong, real'(errsum) / 2000.0);

    nwrong = 0; errsum = 0;
    for (int x = 0; x < 64; x++) begin
      for (int y = 0; y < 64; y++) begin
        drive6(6'(x), 6'(y));
        ex = longint'(x + y);
        if ((x & y & 7) == 0) chk(s6, ex, "R7 R2 width 6 sweep");
        else chk(s6, model(x, y, 6), "R7 R3 width 6 sweep");
        if (longint'(s6) != ex) nwrong++;
        errsum += ex - longint'(s6);
      end
    end
    $display("width 6 exhaustive: error rate %0d/4096, mean error distance %0.3f",
             nwrong, real'(errsum) / 4096.0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule